// File: doc/BRIEF.md
# Serial NAND Page Read Controller

This block turns a read request (a byte address into the flash array and a byte length) into the command traffic a serial NAND needs, and returns the data as a byte stream. It drives a byte-level SPI engine. The engine is assumed to own chip select and clocking. It accepts one command byte at a time, with a flag that closes the current chip-select frame, and it returns the byte it shifted in. Before the first page the controller waits until the device reports that it is idle. For each page it loads the array page into the device cache, polls until the load has finished, and looks at the ECC status. If the page is usable, it fetches the requested slice of that page out of the cache.

A request may cross page boundaries. The controller cuts it into per-page chunks. Each chunk ends at the page end or at the end of the request, whichever comes first. If a page load reports an uncorrectable ECC result, the controller stops before reading that page. It then reports a byte count shorter than the request.

Data leaves on an 8-bit valid/ready port. A byte stays presented, unchanged, until the consumer takes it. While a byte is held, the controller starts no further data transfer on the SPI engine, so back-pressure reaches the serial link and no data is lost or buffered beyond one byte.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, req_ready is 1, and xfer_valid, out_valid and done are 0; ecc_status is 00.
- R2: Before the first page load of a request, the block reads the status feature with the byte sequence 0x0F, 0xC0, 0x00. Bit 0 of the byte returned for the third byte means busy. The block repeats the sequence until bit 0 is clear.
- R3: A page load sends 0x13 and then the page row (byte address shifted right by 11) as three bytes, most significant first. The block then polls the status feature as in R2 until not busy.
- R4: A cache fetch sends 0x03, the column (byte address modulo 2048) as two bytes high first, and one dummy 0x00. It then clocks one 0x00 byte per data byte. The bytes returned are delivered in order as the data for consecutive addresses.
- R5: Each cache fetch moves min(bytes remaining, 2048 minus column) bytes, so a request is split at every 2048-byte page boundary.
- R6: Bits 5:4 of the last status byte after a page load are kept on ecc_status. The value 10 (uncorrectable) ends the request without fetching that page.
- R7: At the end of a request, done pulses for one cycle after the last data byte has been taken. done_count then equals the number of bytes delivered.
- R8: out_data stays stable while out_valid is 1 and out_ready is 0. No data byte is requested from the SPI engine while an undelivered byte is held.
- R9: xfer_byte and xfer_last stay stable while xfer_valid is 1 and xfer_ready is 0. xfer_last is 1 exactly on the final byte of each command frame. No new byte is issued before the response to the previous one.
- R10: A request of length 0 causes no SPI traffic and completes with done and done_count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_addr | input | ADDR_W | Starting byte address in the array |
| req_len | input | LEN_W | Number of bytes to read |
| xfer_valid | output | 1 | Byte to send to the SPI engine |
| xfer_ready | input | 1 | SPI engine accepts the byte |
| xfer_byte | output | 8 | Byte to shift out |
| xfer_last | output | 1 | Final byte of the chip-select frame |
| rsp_valid | input | 1 | Engine returns the byte shifted in (one per accepted byte) |
| rsp_byte | input | 8 | Byte shifted in |
| out_valid | output | 1 | Read data byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle pulse at request completion |
| done_count | output | LEN_W | Bytes delivered for the finished request |
| ecc_status | output | 2 | ECC bits from the latest page load |

## Verification
Requests are placed in the middle of a page, exactly up to a page end, across one boundary and across several. Together these show whether the chunk arithmetic and the row/column split are right at each edge. An uncorrectable page is injected both as the first page and after a partial page, which separates "stop before fetch" from "stop after fetch" and checks the short count. A corrected-error page and a device that starts busy show that only the 10 code aborts and that the pre-poll loops. Random addresses and lengths run under random engine and consumer stalls, which exposes any data loss or reordering under back-pressure.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam logic [7:0] OP_GET_FEAT  = 8'h0F;
  localparam logic [7:0] FEAT_STATUS  = 8'hC0;
  localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
  localparam logic [7:0] OP_CACHE_RD  = 8'h03;
  localparam logic [7:0] BYTE_FILL    = 8'h00;
  localparam int         STAT_BUSY    = 0;
  localparam int         STAT_ECC_LO  = 4;
  localparam logic [1:0] ECC_UNCORR   = 2'b10;

  typedef enum logic [1:0] {PH_POLL, PH_LOAD, PH_READ} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_FINISH} state_e;
endpackage

// File: rtl/nand_rd_chunk.sv
module nand_rd_chunk #(
  parameter int ADDR_W     = 28,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     pos,
  input  logic [LEN_W-1:0]      rem,
  output logic [23:0]           row,
  output logic [PAGE_SHIFT-1:0] col,
  output logic [LEN_W-1:0]      chunk
);
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  logic [PAGE_SHIFT:0] space;
  logic [LEN_W-1:0]    space_ext;

  always_comb begin
    row       = 24'(pos >> PAGE_SHIFT);
    col       = pos[PAGE_SHIFT-1:0];
    space     = (PAGE_SHIFT+1)'(PAGE_BYTES) - {1'b0, col};
    space_ext = LEN_W'(space);
    chunk     = (rem < space_ext) ? rem : space_ext;
  end

  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != '0) |-> (chunk != '0) && (chunk <= rem) &&
                    ((int'(col) + int'(chunk)) <= PAGE_BYTES)); // R5
endmodule

// File: rtl/nand_rd_bytegen.sv
module nand_rd_bytegen
  import nand_rd_pkg::*;
#(
  parameter int IDX_W      = 13,
  parameter int PAGE_SHIFT = 11
) (
  input  phase_e                phase,
  input  logic [IDX_W-1:0]      idx,
  input  logic [23:0]           row,
  input  logic [PAGE_SHIFT-1:0] col,
  output logic [7:0]            tx_byte
);
  logic [15:0] col16;

  always_comb begin
    col16   = 16'(col);
    tx_byte = BYTE_FILL;
    unique case (phase)
      PH_POLL: begin
        if (idx == IDX_W'(0))      tx_byte = OP_GET_FEAT;
        else if (idx == IDX_W'(1)) tx_byte = FEAT_STATUS;
      end
      PH_LOAD: begin
        if (idx == IDX_W'(0))      tx_byte = OP_PAGE_LOAD;
        else if (idx == IDX_W'(1)) tx_byte = row[23:16];
        else if (idx == IDX_W'(2)) tx_byte = row[15:8];
        else                       tx_byte = row[7:0];
      end
      default: begin
        if (idx == IDX_W'(0))      tx_byte = OP_CACHE_RD;
        else if (idx == IDX_W'(1)) tx_byte = col16[15:8];
        else if (idx == IDX_W'(2)) tx_byte = col16[7:0];
      end
    endcase
  end
endmodule

// File: rtl/nand_rd_outbuf.sv
module nand_rd_outbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid); // R8
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nand_rd_pkg::*;
#(
  parameter int ADDR_W     = 28,
  parameter int LEN_W      = 16,
  parameter int PAGE_SHIFT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [7:0]        xfer_byte,
  output logic              xfer_last,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic [1:0]        ecc_status
);
  localparam int IDX_W = PAGE_SHIFT + 2;

  state_e                state;
  phase_e                phase;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      last_idx;
  logic [ADDR_W-1:0]     pos;
  logic [LEN_W-1:0]      rem;
  logic [LEN_W-1:0]      len_q;
  logic [LEN_W-1:0]      delivered;
  logic                  after_load;
  logic [23:0]           row;
  logic [PAGE_SHIFT-1:0] col;
  logic [LEN_W-1:0]      chunk;
  logic                  is_last;
  logic                  data_byte;
  logic                  buf_load;
  logic                  stat_busy;
  logic [1:0]            stat_ecc;
  logic                  rsp_unused;

  nand_rd_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chunk (
    .clk(clk), .rst_n(rst_n), .pos(pos), .rem(rem),
    .row(row), .col(col), .chunk(chunk)
  );

  nand_rd_bytegen #(.IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)) u_gen (
    .phase(phase), .idx(idx), .row(row), .col(col), .tx_byte(xfer_byte)
  );

  always_comb begin
    unique case (phase)
      PH_POLL: last_idx = IDX_W'(2);
      PH_LOAD: last_idx = IDX_W'(3);
      default: last_idx = IDX_W'(3) + IDX_W'(chunk);
    endcase
    is_last    = (idx == last_idx);
    data_byte  = (phase == PH_READ) && (idx >= IDX_W'(4));
    xfer_last  = is_last;
    xfer_valid = (state == ST_SEND) && !(data_byte && out_valid);
    buf_load   = (state == ST_WAIT) && rsp_valid && data_byte;
    req_ready  = (state == ST_IDLE);
    stat_busy  = rsp_byte[STAT_BUSY];
    stat_ecc   = rsp_byte[STAT_ECC_LO +: 2];
  end

  assign rsp_unused = ^{rsp_byte[7:6], rsp_byte[3:1]};

  nand_rd_outbuf #(.W(8)) u_out (
    .clk(clk), .rst_n(rst_n), .load(buf_load), .load_data(rsp_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= PH_POLL;
      idx        <= '0;
      pos        <= '0;
      rem        <= '0;
      len_q      <= '0;
      delivered  <= '0;
      after_load <= 1'b0;
      ecc_status <= 2'b00;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            pos        <= req_addr;
            rem        <= req_len;
            len_q      <= req_len;
            delivered  <= '0;
            idx        <= '0;
            after_load <= 1'b0;
            phase      <= PH_POLL;
            if (req_len == '0) begin
              done       <= 1'b1;
              done_count <= '0;
            end else begin
              state <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (xfer_valid && xfer_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            state <= ST_SEND;
            if (!is_last) begin
              idx <= idx + IDX_W'(1);
            end else begin
              idx <= '0;
              unique case (phase)
                PH_POLL: begin
                  if (!stat_busy) begin
                    if (after_load) begin
                      ecc_status <= stat_ecc;
                      if (stat_ecc == ECC_UNCORR) state <= ST_FINISH;
                      else                        phase <= PH_READ;
                    end else begin
                      phase <= PH_LOAD;
                    end
                  end
                end
                PH_LOAD: begin
                  phase      <= PH_POLL;
                  after_load <= 1'b1;
                end
                default: begin
                  pos       <= pos + ADDR_W'(chunk);
                  rem       <= rem - chunk;
                  delivered <= delivered + chunk;
                  if (rem == chunk) state <= ST_FINISH;
                  else              phase <= PH_LOAD;
                end
              endcase
            end
          end
        end
        default: begin
          if (!out_valid) begin
            done       <= 1'b1;
            done_count <= delivered;
            state      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_byte) && $stable(xfer_last))); // R9

  AST_DONE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= len_q)); // R7

  AST_ECC_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (len_q != '0) && (ecc_status == ECC_UNCORR)) |-> (done_count < len_q)); // R6

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid); // R7
endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;
  localparam int ADDR_W = 28;
  localparam int LEN_W  = 16;
  localparam int PAGE   = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              xfer_valid, xfer_ready, xfer_last;
  logic [7:0]        xfer_byte;
  logic              rsp_valid;
  logic [7:0]        rsp_byte;
  logic              out_valid, out_ready;
  logic [7:0]        out_data;
  logic              done;
  logic [LEN_W-1:0]  done_count;
  logic [1:0]        ecc_status;

  nand_page_reader #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_byte(xfer_byte), .xfer_last(xfer_last),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done),
    .done_count(done_count), .ecc_status(ecc_status)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_at(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'h5A;
  endfunction

  int bad_row = -1;

  function automatic logic [1:0] ecc_of(input int r);
    if (r == bad_row) return 2'b10;
    if ((r % 4) == 1) return 2'b01;
    return 2'b00;
  endfunction

  task automatic expect_read(input int addr, input int len,
                             output int cnt, output logic [1:0] ecc);
    int p = addr;
    int r = len;
    cnt = 0;
    ecc = 2'b00;
    while (r > 0) begin
      int c;
      ecc = ecc_of(p / PAGE);
      if (ecc == 2'b10) break;
      c = PAGE - (p % PAGE);
      if (r < c) c = r;
      cnt += c;
      p += c;
      r -= c;
    end
  endtask

  // device + engine model state
  int         busy_left = 0;
  int         row_loaded = 0;
  logic [1:0] ecc_cur = 2'b00;
  logic [7:0] op = 8'h00;
  int         tidx = 0;
  logic [7:0] b1, b2;
  int         col_cur = 0;
  int         exp_pos = 0;
  int         base_addr = 0;
  int         base_len = 0;
  int         xfers = 0;
  bit         pend = 0;
  int         dly = 0;
  logic [7:0] pend_b = 8'h00;

  task automatic handle(input logic [7:0] b, input logic lst);
    logic [7:0] resp = 8'h00;
    xfers++;
    if (tidx == 0) op = b;
    case (op)
      8'h0F: begin
        if (tidx == 1) chk(b == 8'hC0, "R2", "status feature address", b, 8'hC0);
        if (tidx == 2) begin
          if (busy_left > 0) begin resp = 8'h01; busy_left--; end
          else resp = {2'b00, ecc_cur, 4'b0000};
        end
        chk(lst == (tidx == 2), "R9", "poll frame end flag", lst, tidx == 2);
      end
      8'h13: begin
        if (tidx == 0) chk(busy_left == 0, "R2", "load issued while busy", busy_left, 0);
        if (tidx == 1) b1 = b;
        if (tidx == 2) b2 = b;
        if (tidx == 3) begin
          row_loaded = int'({b1, b2, b});
          chk(row_loaded == exp_pos / PAGE, "R3", "load row", row_loaded, exp_pos / PAGE);
          ecc_cur   = ecc_of(row_loaded);
          busy_left = 1 + int'($urandom % 3);
        end
        chk(lst == (tidx == 3), "R9", "load frame end flag", lst, tidx == 3);
      end
      8'h03: begin
        if (tidx == 1) b1 = b;
        if (tidx == 2) begin
          col_cur = int'({b1, b});
          chk(col_cur == exp_pos % PAGE, "R4", "fetch column", col_cur, exp_pos % PAGE);
          chk(row_loaded == exp_pos / PAGE, "R4", "fetch row", row_loaded, exp_pos / PAGE);
          chk(busy_left == 0, "R3", "fetch while busy", busy_left, 0);
          chk(ecc_cur != 2'b10, "R6", "fetch of uncorrectable page", ecc_cur, 0);
        end
        if (tidx == 3) chk(b == 8'h00, "R4", "dummy byte", b, 0);
        if (tidx >= 4) resp = mem_at(row_loaded * PAGE + col_cur + tidx - 4);
        if (lst) begin
          int n = tidx - 3;
          int remm = base_len - (exp_pos - base_addr);
          int ec = PAGE - (exp_pos % PAGE);
          if (remm < ec) ec = remm;
          chk(n == ec, "R5", "chunk length", n, ec);
          exp_pos += n;
        end
      end
      default: chk(1'b0, "R9", "unknown opcode", b, 0);
    endcase
    if (lst) tidx = 0;
    else     tidx++;
    pend   = 1'b1;
    dly    = int'($urandom % 3);
    pend_b = resp;
  endtask

  initial begin
    xfer_ready = 1'b0;
    rsp_valid  = 1'b0;
    rsp_byte   = 8'h00;
    forever begin
      bit r;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rsp_valid = 1'b1;
          rsp_byte  = pend_b;
          pend      = 1'b0;
        end else begin
          dly--;
        end
      end
      r = ($urandom % 4) != 0;
      xfer_ready = r;
      if (rst_n && xfer_valid && r) handle(xfer_byte, xfer_last);
    end
  end

  // consumer
  int         got = 0;
  bit         held = 0;
  logic [7:0] held_data = 8'h00;

  initial begin
    out_ready = 1'b0;
    forever begin
      bit r;
      @(negedge clk);
      if (held)
        chk(out_valid && (out_data == held_data), "R8", "held output byte", out_data, held_data);
      r = ($urandom % 3) != 0;
      out_ready = r;
      held      = rst_n && out_valid && !r;
      held_data = out_data;
      if (rst_n && out_valid && r) begin
        chk(out_data == mem_at(base_addr + got), "R4", "data byte",
            out_data, mem_at(base_addr + got));
        got++;
      end
    end
  end

  // completion monitor
  bit              done_seen = 0;
  int              done_cnt_v = 0;
  logic [1:0]      done_ecc_v = 2'b00;

  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done_seen  = 1'b1;
        done_cnt_v = int'(done_count);
        done_ecc_v = ecc_status;
      end
    end
  end

  task automatic run_req(input int addr, input int len, input int pre_busy);
    int         ecnt;
    logic [1:0] eecc;
    int         x0;
    int         waited = 0;
    expect_read(addr, len, ecnt, eecc);
    @(negedge clk);
    busy_left = pre_busy;
    base_addr = addr;
    base_len  = len;
    exp_pos   = addr;
    got       = 0;
    done_seen = 1'b0;
    x0        = xfers;
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_seen && waited < 60000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_seen, "R7", "request completion", done_seen, 1);
    chk(done_cnt_v == ecnt, "R7", "done count", done_cnt_v, ecnt);
    chk(got == ecnt, "R7", "bytes delivered", got, ecnt);
    chk(exp_pos == addr + ecnt, "R5", "bytes fetched", exp_pos - addr, ecnt);
    if (len > 0) chk(done_ecc_v == eecc, "R6", "ecc status port", done_ecc_v, eecc);
    else         chk(xfers == x0, "R10", "traffic for empty request", xfers - x0, 0);
    if (pre_busy > 0) chk(busy_left == 0 || xfers > x0, "R2", "pre-poll consumed busy", busy_left, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v    = $urandom(32'd20517);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_len   = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(xfer_valid == 1'b0, "R1", "xfer_valid after reset", xfer_valid, 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(ecc_status == 2'b00, "R1", "ecc after reset", ecc_status, 0);

    run_req(100, 16, 0);                 // mid-page
    run_req(0, 0, 0);                    // R10 empty request
    run_req(2043, 20, 0);                // R5 crosses one boundary
    run_req(2 * PAGE + 2000, 48, 0);     // ends exactly at page end
    run_req(5000, 10, 3);                // R2 device busy at start
    run_req(PAGE + 10, 30, 0);           // corrected ECC page, no abort
    bad_row = 6;
    run_req(5 * PAGE + 2000, 5000, 0);   // R6 abort after partial chunk
    bad_row = 9;
    run_req(9 * PAGE + 5, 100, 0);       // R6 abort on first page
    run_req(0, 0, 0);                    // R10 after an abort
    bad_row = -1;
    run_req(3 * PAGE, 2 * PAGE + 7, 0);  // R5 several pages

    for (int i = 0; i < 10; i++) begin
      int a = int'($urandom % (1 << 20));
      int l = int'($urandom % 700);
      bad_row = (($urandom % 3) == 0) ? (a / PAGE + 1) : -1;
      run_req(a, l, int'($urandom % 3));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule